// File: doc/BRIEF.md
# Receive Byte-to-Word Buffer Packer

This block sits between a serial channel's receive FIFO and a DMA engine. It accepts received bytes one at a time and packs them into 32-bit words for a data buffer in memory. Each output word carries a byte-enable mask, and bytes fill the lanes in little-endian or big-endian order. A word is closed early at a FIFO transfer boundary, so a word can leave unused lanes as zeroed holes.

Status bytes are inserted into the byte stream by the packer itself. There are two modes. In per-byte mode every data byte is followed by its own status byte (parity, parity error, framing error), which is copied through unchanged. In frame mode a single status byte follows the last data byte of a frame. In both modes a status byte is counted and stored exactly like data. The packer keeps a running count of the bytes placed in the current buffer. It closes the buffer when the count reaches the programmed size or when a frame ends. If the data alone fills a buffer, the status byte and the frame-end mark spill into the next buffer.

Top module: `rx_word_packer`

## Requirements
- R1: After reset `inReady` is 1 and `outValid`, `bufDone` and `frameEnd` are 0.
- R2: With `cfgBigEndian`=0, the k-th byte placed in a word (k=0..3) goes to bits [8k+7:8k], and the mask is 0001, 0011, 0111 or 1111 for 1 to 4 bytes.
- R3: With `cfgBigEndian`=1, the k-th byte goes to bits [31-8k:24-8k], and the mask is 1000, 1100, 1110 or 1111.
- R4: `cfgThresh` codes 0,1,2,3,4 select transfers of 1,2,4,16,24 bytes. A word is also closed when the placed-byte count within the current transfer reaches that size. Lanes that are not written read as zero. The transfer count restarts after each transfer and after each frame end.
- R5: With `cfgPerByte`=1, each accepted data byte is followed by `inStatus` as the next placed byte. `inReady` is 0 for exactly the one cycle in which the status is inserted.
- R6: With `cfgPerByte`=0, `inStatus` is placed only after a byte accepted with `inLast`=1. Other bytes get no status.
- R7: `bufCount` is the number of bytes placed in the closed buffer, status bytes included. It is never larger than `cfgBufSize`, and a buffer closes with `bufDone` as soon as the count equals `cfgBufSize`.
- R8: If a frame's data bytes exactly fill the buffer, that buffer closes with `frameEnd`=0. The status byte then opens the next buffer, which closes with count 1 and `frameEnd`=1.
- R9: With `bufDone`, `lastLanes` gives the number of valid bytes in the final word: 00 for four, and 01, 10 or 11 for one, two or three.
- R10: The status byte that follows an `inLast` byte closes its word and its buffer. `frameEnd` is 1 only together with that `bufDone`.
- R11: Each output event (`outValid`, with `bufDone`, `bufCount`, `lastLanes` and `frameEnd`) is registered and appears one cycle after the byte that closes the word is placed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgPerByte | input | 1 | 1: status after every data byte; 0: one status per frame |
| cfgBigEndian | input | 1 | 1: first byte in most significant lane |
| cfgThresh | input | 3 | FIFO transfer size code (1,2,4,16,24 bytes) |
| cfgBufSize | input | CNT_W | Buffer size in bytes, 1 or more |
| inValid | input | 1 | Input byte valid |
| inReady | output | 1 | Input byte accepted when high with inValid |
| inByte | input | 8 | Received data byte |
| inStatus | input | 8 | Status byte to append |
| inLast | input | 1 | Byte is the last data byte of a frame |
| outValid | output | 1 | Output word valid |
| outWord | output | 32 | Packed word |
| outMask | output | 4 | Byte-enable mask |
| bufDone | output | 1 | Current buffer closed with this word |
| bufCount | output | CNT_W | Bytes placed in the closed buffer |
| lastLanes | output | 2 | Valid bytes in final word (00 = four) |
| frameEnd | output | 1 | Closed buffer ends the frame |

## Verification
The bench keeps the default 13-bit count width. At run time it sweeps both status modes, both lane orders, all five transfer sizes and the buffer sizes 1 to 5 and 7 to 9. In every configuration it sends frames of one to seven data bytes. Small buffer sizes make buffer closes fall at every lane position, both before and after an inserted status byte. This covers exact-fill spills and one-byte buffers, and it lets transfer, word and buffer boundaries coincide in every combination. A directed frame of four bytes into a four-byte buffer checks the spill case in isolation.

// File: rtl/rx_pack_pkg.sv
package rx_pack_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = $clog2(LANES);
  localparam int THR_W  = 5;

  typedef struct packed {
    logic              place;
    logic              useStat;
    logic              capStat;
    logic              closeWord;
    logic              closeBuf;
    logic              frameEnd;
    logic [LANE_W-1:0] laneIdx;
    logic [LANE_W-1:0] lastLanes;
  } packStrobe_t;

  function automatic logic [THR_W-1:0] thrBytes(input logic [2:0] code);
    case (code)
      3'd0:    thrBytes = THR_W'(1);
      3'd1:    thrBytes = THR_W'(2);
      3'd2:    thrBytes = THR_W'(4);
      3'd3:    thrBytes = THR_W'(16);
      default: thrBytes = THR_W'(24);
    endcase
  endfunction
endpackage

// File: rtl/rx_pack_ctrl.sv
module rx_pack_ctrl
  import rx_pack_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgPerByte,
  input  logic             cfgBigEndian,
  input  logic [2:0]       cfgThresh,
  input  logic [CNT_W-1:0] cfgBufSize,
  input  logic             inValid,
  input  logic             inLast,
  output logic             inReady,
  output packStrobe_t      strobe,
  output logic [CNT_W-1:0] placeCount
);
  logic [LANE_W:0]    laneCnt, newLane;
  logic [THR_W-1:0]   chunkCnt, newChunk, thr;
  logic [CNT_W-1:0]   bufCnt, newBuf;
  logic               statPending, pendLast;
  logic               accept, needStat, isEnd, chunkDone;

  assign thr      = thrBytes(cfgThresh);
  assign inReady  = !statPending;
  assign accept   = inValid && inReady;
  assign needStat = accept && (cfgPerByte || inLast);
  assign isEnd    = statPending && pendLast;
  assign newLane  = laneCnt + 1'b1;
  assign newChunk = chunkCnt + 1'b1;
  assign newBuf   = bufCnt + 1'b1;
  assign chunkDone = (newChunk == thr);

  always_comb begin
    strobe           = '0;
    strobe.place     = statPending || accept;
    strobe.useStat   = statPending;
    strobe.capStat   = needStat;
    strobe.frameEnd  = isEnd;
    strobe.closeBuf  = isEnd || (newBuf == cfgBufSize);
    strobe.closeWord = strobe.closeBuf || chunkDone || (newLane == (LANE_W+1)'(LANES));
    strobe.laneIdx   = cfgBigEndian ? LANE_W'(LANES-1) - laneCnt[LANE_W-1:0]
                                    : laneCnt[LANE_W-1:0];
    strobe.lastLanes = newLane[LANE_W-1:0];
  end
  assign placeCount = newBuf;

  always_ff @(posedge clk) begin
    if (rst) begin
      laneCnt     <= '0;
      chunkCnt    <= '0;
      bufCnt      <= '0;
      statPending <= 1'b0;
      pendLast    <= 1'b0;
    end else begin
      if (strobe.place) begin
        laneCnt  <= strobe.closeWord ? '0 : newLane;
        chunkCnt <= (chunkDone || isEnd) ? '0 : newChunk;
        bufCnt   <= strobe.closeBuf ? '0 : newBuf;
      end
      if (needStat) begin
        statPending <= 1'b1;
        pendLast    <= inLast;
      end else if (statPending) begin
        statPending <= 1'b0;
        pendLast    <= 1'b0;
      end
    end
  end

  // R7
  buf_count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (cfgBufSize != '0) |-> (bufCnt < cfgBufSize));
  // R5
  status_insert_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && (cfgPerByte || inLast)) |=> !inReady);
  // R5
  status_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !inReady |=> inReady);
endmodule

// File: rtl/rx_pack_dp.sv
module rx_pack_dp
  import rx_pack_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgBigEndian,
  input  packStrobe_t       strobe,
  input  logic [CNT_W-1:0]  placeCount,
  input  logic [7:0]        inByte,
  input  logic [7:0]        inStatus,
  output logic              outValid,
  output logic [8*LANES-1:0] outWord,
  output logic [LANES-1:0]  outMask,
  output logic              bufDone,
  output logic [CNT_W-1:0]  bufCount,
  output logic [LANE_W-1:0] lastLanes,
  output logic              frameEnd
);
  logic [7:0]          statReg, placeByte;
  logic [8*LANES-1:0]  acc, nextAcc;
  logic [LANES-1:0]    accMask, nextMask;

  assign placeByte = strobe.useStat ? statReg : inByte;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic hit;
    assign hit = strobe.place && (strobe.laneIdx == LANE_W'(g));
    assign nextAcc[8*g +: 8] = hit ? placeByte : acc[8*g +: 8];
    assign nextMask[g]       = hit || accMask[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statReg   <= '0;
      acc       <= '0;
      accMask   <= '0;
      outValid  <= 1'b0;
      outWord   <= '0;
      outMask   <= '0;
      bufDone   <= 1'b0;
      bufCount  <= '0;
      lastLanes <= '0;
      frameEnd  <= 1'b0;
    end else begin
      if (strobe.capStat) statReg <= inStatus;
      outValid <= strobe.place && strobe.closeWord;
      bufDone  <= strobe.place && strobe.closeBuf;
      frameEnd <= strobe.place && strobe.frameEnd;
      if (strobe.place) begin
        if (strobe.closeWord) begin
          outWord   <= nextAcc;
          outMask   <= nextMask;
          bufCount  <= placeCount;
          lastLanes <= strobe.lastLanes;
          acc       <= '0;
          accMask   <= '0;
        end else begin
          acc     <= nextAcc;
          accMask <= nextMask;
        end
      end
    end
  end

  // R4
  mask_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outMask != '0));
  // R10
  done_has_word_chk: assert property (@(posedge clk) disable iff (rst)
    bufDone |-> outValid);
  // R10
  frame_end_done_chk: assert property (@(posedge clk) disable iff (rst)
    frameEnd |-> bufDone);
  // R2
  le_mask_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !cfgBigEndian) |-> (outMask == 4'b0001 || outMask == 4'b0011 ||
                                     outMask == 4'b0111 || outMask == 4'b1111));
  // R3
  be_mask_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && cfgBigEndian) |-> (outMask == 4'b1000 || outMask == 4'b1100 ||
                                    outMask == 4'b1110 || outMask == 4'b1111));
endmodule

// File: rtl/rx_word_packer.sv
module rx_word_packer
  import rx_pack_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgPerByte,
  input  logic             cfgBigEndian,
  input  logic [2:0]       cfgThresh,
  input  logic [CNT_W-1:0] cfgBufSize,
  input  logic             inValid,
  output logic             inReady,
  input  logic [7:0]       inByte,
  input  logic [7:0]       inStatus,
  input  logic             inLast,
  output logic             outValid,
  output logic [31:0]      outWord,
  output logic [3:0]       outMask,
  output logic             bufDone,
  output logic [CNT_W-1:0] bufCount,
  output logic [1:0]       lastLanes,
  output logic             frameEnd
);
  packStrobe_t      strobe;
  logic [CNT_W-1:0] placeCount;

  rx_pack_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rst(rst), .cfgPerByte(cfgPerByte), .cfgBigEndian(cfgBigEndian),
    .cfgThresh(cfgThresh), .cfgBufSize(cfgBufSize), .inValid(inValid),
    .inLast(inLast), .inReady(inReady), .strobe(strobe), .placeCount(placeCount)
  );

  rx_pack_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rst(rst), .cfgBigEndian(cfgBigEndian), .strobe(strobe),
    .placeCount(placeCount), .inByte(inByte), .inStatus(inStatus),
    .outValid(outValid), .outWord(outWord), .outMask(outMask), .bufDone(bufDone),
    .bufCount(bufCount), .lastLanes(lastLanes), .frameEnd(frameEnd)
  );
endmodule

// File: tb/tb_rx_word_packer.sv
module tb_rx_word_packer;
  localparam int CNT_W = 13;
  localparam int QD    = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgPerByte = 1'b0, cfgBigEndian = 1'b0;
  logic [2:0] cfgThresh = 3'd2;
  logic [CNT_W-1:0] cfgBufSize = CNT_W'(8);
  logic inValid = 1'b0, inLast = 1'b0;
  logic [7:0] inByte = '0, inStatus = '0;
  logic inReady, outValid, bufDone, frameEnd;
  logic [31:0] outWord;
  logic [3:0] outMask;
  logic [CNT_W-1:0] bufCount;
  logic [1:0] lastLanes;

  always #2 clk = ~clk;

  rx_word_packer #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .cfgPerByte(cfgPerByte), .cfgBigEndian(cfgBigEndian),
    .cfgThresh(cfgThresh), .cfgBufSize(cfgBufSize), .inValid(inValid),
    .inReady(inReady), .inByte(inByte), .inStatus(inStatus), .inLast(inLast),
    .outValid(outValid), .outWord(outWord), .outMask(outMask), .bufDone(bufDone),
    .bufCount(bufCount), .lastLanes(lastLanes), .frameEnd(frameEnd)
  );

  int checks = 0, fails = 0, monChecks = 0, monFails = 0;
  logic [31:0] expWord [QD];
  logic [3:0]  expMask [QD];
  logic        expDone [QD];
  logic [CNT_W-1:0] expCnt [QD];
  logic [1:0]  expLanes [QD];
  logic        expFe [QD];
  int wr = 0, rd = 0;
  int mLane, mChunk, mBuf, thrN;
  logic [31:0] mAcc;
  logic [3:0] mMask;
  logic [CNT_W-1:0] prevCnt, lastCnt;
  logic prevFe, lastFe;
  int cycles = 0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mLane = 0; mChunk = 0; mBuf = 0; mAcc = '0; mMask = '0;
    case (cfgThresh)
      3'd0: thrN = 1; 3'd1: thrN = 2; 3'd2: thrN = 4; 3'd3: thrN = 16;
      default: thrN = 24;
    endcase
  endtask

  // model of one placed byte, built from R2, R3, R4, R7, R9, R10
  task automatic modelPlace(input logic [7:0] b, input logic isEnd);
    int lane;
    logic bufClose;
    lane = cfgBigEndian ? 3 - mLane : mLane;
    mAcc[8*lane +: 8] = b;
    mMask[lane] = 1'b1;
    mLane++; mChunk++; mBuf++;
    bufClose = isEnd || (mBuf == int'(cfgBufSize));
    if (bufClose || mLane == 4 || mChunk == thrN) begin
      expWord[wr % QD] = mAcc; expMask[wr % QD] = mMask;
      expDone[wr % QD] = bufClose; expCnt[wr % QD] = CNT_W'(mBuf);
      expLanes[wr % QD] = 2'(mLane); expFe[wr % QD] = isEnd;
      wr++;
      mLane = 0; mAcc = '0; mMask = '0;
    end
    if (mChunk == thrN || isEnd) mChunk = 0;
    if (bufClose) mBuf = 0;
  endtask

  // drive one data byte; the status insertion follows per R5 / R6
  task automatic sendByte(input logic [7:0] d, input logic [7:0] s, input logic last);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inByte = d; inStatus = s; inLast = last; inValid = 1'b1;
    modelPlace(d, 1'b0);
    if (cfgPerByte || last) modelPlace(s, last);
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
    if (cfgPerByte || last)
      chk(!inReady, "R5/R6 ready low during status insert", inReady, 0);
    else
      chk(inReady, "R6 no status without last", inReady, 1);
  endtask

  task automatic doReset();
    inValid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    wr = 0; rd = 0;
    modelReset();
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst && outValid) begin
      monChecks++;
      if (rd == wr) begin
        monFails++;
        $display("FAIL R11 unexpected word actual=%0h expected=none", outWord);
      end else begin
        if (outWord !== expWord[rd % QD] || outMask !== expMask[rd % QD]) begin
          monFails++;
          $display("FAIL %s/R4 word actual=%0h/%0h expected=%0h/%0h",
                   cfgBigEndian ? "R3" : "R2", outWord, outMask,
                   expWord[rd % QD], expMask[rd % QD]);
        end
        monChecks++;
        if (bufDone !== expDone[rd % QD] || frameEnd !== expFe[rd % QD]) begin
          monFails++;
          $display("FAIL R10 done/frameEnd actual=%0b%0b expected=%0b%0b",
                   bufDone, frameEnd, expDone[rd % QD], expFe[rd % QD]);
        end
        if (expDone[rd % QD]) begin
          monChecks++;
          if (bufCount !== expCnt[rd % QD]) begin
            monFails++;
            $display("FAIL R7 bufCount actual=%0d expected=%0d", bufCount, expCnt[rd % QD]);
          end
          monChecks++;
          if (lastLanes !== expLanes[rd % QD]) begin
            monFails++;
            $display("FAIL R9 lastLanes actual=%0d expected=%0d", lastLanes, expLanes[rd % QD]);
          end
          prevCnt = lastCnt; prevFe = lastFe;
          lastCnt = bufCount; lastFe = frameEnd;
        end
        rd++;
      end
    end else if (!rst && (bufDone || frameEnd)) begin
      monChecks++; monFails++;
      $display("FAIL R10 done without word actual=1 expected=0");
    end
    if (cycles > 190000) begin
      $display("FAIL watchdog actual=%0d expected<190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures",
               checks + monChecks + 1, fails + monFails + 1);
      $finish;
    end
  end

  initial begin
    doReset();
    @(negedge clk);
    // R1
    chk(inReady === 1'b1, "R1 inReady after reset", inReady, 1);
    chk(outValid === 1'b0 && bufDone === 1'b0 && frameEnd === 1'b0,
        "R1 outputs idle after reset", {outValid, bufDone, frameEnd}, 0);

    // R8 directed spill: 4 data bytes into a 4-byte buffer, frame mode
    cfgPerByte = 1'b0; cfgBigEndian = 1'b0; cfgThresh = 3'd2; cfgBufSize = CNT_W'(4);
    doReset();
    for (int i = 0; i < 4; i++) sendByte(8'(8'h11 * (i + 1)), 8'hA5, i == 3);
    repeat (4) @(negedge clk);
    chk(prevCnt == CNT_W'(4) && prevFe == 1'b0, "R8 full buffer without frame end",
        {prevFe, prevCnt}, 4);
    chk(lastCnt == CNT_W'(1) && lastFe == 1'b1, "R8 status spills to next buffer",
        {lastFe, lastCnt}, {1'b1, CNT_W'(1)});
    chk(rd == wr, "R11 all directed events seen", rd, wr);

    // sweep: R2 R3 R4 R5 R6 R7 R9 R10 over modes, orders, thresholds, sizes
    for (int pb = 0; pb < 2; pb++)
      for (int be = 0; be < 2; be++)
        for (int th = 0; th < 5; th++)
          for (int sz = 1; sz <= 9; sz++) begin
            if (sz == 6) continue;
            cfgPerByte = pb[0]; cfgBigEndian = be[0];
            cfgThresh = 3'(th); cfgBufSize = CNT_W'(sz);
            doReset();
            for (int fl = 1; fl <= 7; fl++)
              for (int i = 0; i < fl; i++)
                sendByte(8'(fl * 16 + i + 1), 8'(8'h80 | (fl * 8 + i)), i == fl - 1);
            repeat (4) @(negedge clk);
            chk(rd == wr, "R11 event count per configuration", rd, wr);
          end

    $display("End of test - %0d assertions evaluated, %0d failures",
             checks + monChecks, fails + monFails);
    $finish;
  end
endmodule